// File: doc/BRIEF.md
# Phase Resynchronization Decision Logic

This block decides when a two-channel switching controller has to realign the phase of its second stage. Once per second-stage switching period a strobe arrives together with a flag that says whether the output was identified correctly. The block keeps a leaky score of misidentifications. Each miss adds one to the score and each good period takes two away. The score saturates at both ends.

A separate counter measures how many channel-1 switching periods have passed since the last realignment. It provides hysteresis, so that realignments cannot follow one another too closely. A one-clock request is issued when both conditions are met: the score is above a programmable limit, and the hysteresis window has elapsed. The surrounding controller acts on that request. One configuration byte carries both 4-bit settings, and a single enable bit gates the whole decision.

A small state machine follows the decision. `ST_OFF` means the enable is low. `ST_HOLDOFF` means the hysteresis window is still running. `ST_ARMED` means the window is satisfied and the block is waiting for the score. `ST_FIRE` is the single cycle in which the request is driven.

The transitions are evaluated every clock from the counter values after that cycle's update:
- Enable low leads to `ST_OFF`.
- A met decision leads to `ST_FIRE`.
- Otherwise the block goes to `ST_ARMED` if the window has elapsed, and to `ST_HOLDOFF` if it has not.

`ST_FIRE` clears both counters as it is entered.

Top module: `phase_resync_ctrl`

## Requirements
- R1: A second-stage strobe with `id_ok` low raises the error score by one, and the score stops at a ceiling of 31.
- R2: A second-stage strobe with `id_ok` high lowers the error score by two, and the score never goes below zero.
- R3: A request needs the error score, after this cycle's update, to be strictly greater than the threshold field.
- R4: A request also needs at least the hold field's number of channel-1 strobes since the previous request. Only `ch1_tick` advances this count, and the count saturates at the hold value.
- R5: While `resync_en` is low no request is issued. The counters keep tracking, so raising the enable can produce a request on the following clock.
- R6: `cfg_byte[3:0]` is the error threshold (0 to 15) and `cfg_byte[7:4]` is the hold count (0 to 15), both unsigned.
- R7: Issuing a request clears the error score to zero and restarts the channel-1 count from zero.
- R8: After reset the channel-1 count starts saturated, so hysteresis does not block the first request.
- R9: When both strobes arrive in the same clock, both counters update and the decision uses the updated values in that same clock.
- R10: `resync_req` is high for exactly one clock, in the cycle after the clock edge that sampled the triggering input. A synchronous active-high `rst` clears all counters and drops the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resync_en | input | 1 | Enables issuing requests |
| cfg_byte | input | 8 | [7:4] hold count in channel-1 periods, [3:0] error threshold |
| stage2_tick | input | 1 | One-clock strobe per second-stage switching period |
| id_ok | input | 1 | Output identified correctly in this second-stage period |
| ch1_tick | input | 1 | One-clock strobe per channel-1 switching period |
| resync_req | output | 1 | One-clock resynchronization request |

## Verification
A wrong error score appears at the port as a request that comes one strobe early or late. The scenarios are arranged so that a lost ceiling, a wrap below zero or a missed clear each move the request by at least one strobe. A wrong channel-1 count delays or advances the request by whole channel-1 periods. Because the request is registered once, every fault becomes visible on the clock right after the strobe that exposes it. The same-cycle case tells apart a design that decides on the values from before the update.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HOLDOFF = 2'd1,
        ST_ARMED   = 2'd2,
        ST_FIRE    = 2'd3
    } prc_state_t;

endpackage

// File: rtl/prc_err_tracker.sv
module prc_err_tracker #(
    parameter int ERR_W    = 5,
    parameter int ERR_CEIL = 31,
    parameter int INC_STEP = 1,
    parameter int DEC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ok,
    input  logic             clear,
    output logic [ERR_W-1:0] err_q,
    output logic [ERR_W-1:0] err_next
);
    localparam logic [ERR_W:0]   UP_STEP  = (ERR_W+1)'(INC_STEP);
    localparam logic [ERR_W:0]   CEIL_EXT = (ERR_W+1)'(ERR_CEIL);
    localparam logic [ERR_W-1:0] DN_STEP  = ERR_W'(DEC_STEP);

    logic [ERR_W:0] up_sum;

    // Score after this cycle's strobe, before any clear
    always_comb begin
        up_sum   = {1'b0, err_q} + UP_STEP;
        err_next = err_q;
        if (tick) begin
            if (ok) begin
                err_next = (err_q >= DN_STEP) ? (err_q - DN_STEP) : '0;
            end else begin
                err_next = (up_sum > CEIL_EXT) ? CEIL_EXT[ERR_W-1:0] : up_sum[ERR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_q <= '0;
        end else begin
            err_q <= err_next;
        end
    end

endmodule

// File: rtl/prc_hold_timer.sv
module prc_hold_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] hold_q,
    output logic             elapsed
);
    logic [CNT_W-1:0] hold_next;

    always_comb begin
        hold_next = hold_q;
        if (tick && (hold_q < limit)) begin
            hold_next = hold_q + 1'b1;
        end
        elapsed = (hold_next >= limit);
    end

    // Starts saturated so the first decision is not held off
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '1;
        end else if (clear) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_next;
        end
    end

endmodule

// File: rtl/prc_decide_fsm.sv
module prc_decide_fsm
    import prc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic err_over,
    input  logic hold_done,
    output logic fire_now,
    output logic req
);
    prc_state_t state_q, state_d;

    function automatic prc_state_t pick(input logic en, input logic over, input logic done);
        if (!en) begin
            return ST_OFF;
        end else if (over && done) begin
            return ST_FIRE;
        end else if (done) begin
            return ST_ARMED;
        end
        return ST_HOLDOFF;
    endfunction

    // Next-state logic: every state re-evaluates from updated counters
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     state_d = pick(enable, err_over, hold_done);
            ST_HOLDOFF: state_d = pick(enable, err_over, hold_done);
            ST_ARMED:   state_d = pick(enable, err_over, hold_done);
            ST_FIRE:    state_d = pick(enable, err_over, hold_done);
            default:    state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        fire_now = (state_d == ST_FIRE);
        req      = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/phase_resync_ctrl.sv
module phase_resync_ctrl #(
    parameter int FIELD_W  = 4,
    parameter int ERR_W    = 5,
    parameter int ERR_CEIL = 31,
    parameter int INC_STEP = 1,
    parameter int DEC_STEP = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 resync_en,
    input  logic [2*FIELD_W-1:0] cfg_byte,
    input  logic                 stage2_tick,
    input  logic                 id_ok,
    input  logic                 ch1_tick,
    output logic                 resync_req
);
    logic [FIELD_W-1:0] thr_field;
    logic [FIELD_W-1:0] hold_field;
    logic [ERR_W-1:0]   err_cnt;
    logic [ERR_W-1:0]   err_next;
    logic [FIELD_W-1:0] hold_cnt;
    logic               hold_done;
    logic               err_over;
    logic               fire_now;

    assign thr_field  = cfg_byte[FIELD_W-1:0];
    assign hold_field = cfg_byte[2*FIELD_W-1:FIELD_W];
    assign err_over   = (err_next > ERR_W'(thr_field));

    prc_err_tracker #(
        .ERR_W   (ERR_W),
        .ERR_CEIL(ERR_CEIL),
        .INC_STEP(INC_STEP),
        .DEC_STEP(DEC_STEP)
    ) i_err (
        .clk     (clk),
        .rst     (rst),
        .tick    (stage2_tick),
        .ok      (id_ok),
        .clear   (fire_now),
        .err_q   (err_cnt),
        .err_next(err_next)
    );

    prc_hold_timer #(
        .CNT_W(FIELD_W)
    ) i_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (ch1_tick),
        .clear  (fire_now),
        .limit  (hold_field),
        .hold_q (hold_cnt),
        .elapsed(hold_done)
    );

    prc_decide_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .enable   (resync_en),
        .err_over (err_over),
        .hold_done(hold_done),
        .fire_now (fire_now),
        .req      (resync_req)
    );

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
    parameter int FIELD_W  = 4,
    parameter int ERR_W    = 5,
    parameter int ERR_CEIL = 31
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 resync_en,
    input logic [2*FIELD_W-1:0] cfg_byte,
    input logic                 stage2_tick,
    input logic                 id_ok,
    input logic                 ch1_tick,
    input logic                 resync_req,
    input logic [ERR_W-1:0]     err_cnt,
    input logic [FIELD_W-1:0]   hold_cnt
);
    localparam logic [ERR_W-1:0] CEIL_V = ERR_W'(ERR_CEIL);

    assert_err_up_R1: assert property (@(posedge clk) disable iff (rst)
        (stage2_tick && !id_ok) |=> (resync_req ||
            err_cnt == (($past(err_cnt) == CEIL_V) ? CEIL_V : $past(err_cnt) + 1'b1)));

    assert_err_down_R2: assert property (@(posedge clk) disable iff (rst)
        (stage2_tick && id_ok) |=> (resync_req ||
            err_cnt == (($past(err_cnt) >= 2) ? $past(err_cnt) - 2'd2 : '0)));

    assert_err_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !stage2_tick |=> (resync_req || $stable(err_cnt)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !ch1_tick |=> (resync_req || $stable(hold_cnt)));

    assert_gated_off_R5: assert property (@(posedge clk) disable iff (rst)
        !resync_en |=> !resync_req);

    assert_clear_on_req_R7: assert property (@(posedge clk) disable iff (rst)
        resync_req |-> (err_cnt == '0 && hold_cnt == '0));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (resync_req && cfg_byte[FIELD_W-1:0] != '0) |=> !resync_req);

endmodule

bind phase_resync_ctrl prc_checker #(
    .FIELD_W (FIELD_W),
    .ERR_W   (ERR_W),
    .ERR_CEIL(ERR_CEIL)
) i_prc_checker (
    .clk        (clk),
    .rst        (rst),
    .resync_en  (resync_en),
    .cfg_byte   (cfg_byte),
    .stage2_tick(stage2_tick),
    .id_ok      (id_ok),
    .ch1_tick   (ch1_tick),
    .resync_req (resync_req),
    .err_cnt    (err_cnt),
    .hold_cnt   (hold_cnt)
);

// File: tb/test_phase_resync_ctrl.sv
module test_phase_resync_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       resync_en = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       stage2_tick = 1'b0;
    logic       id_ok = 1'b0;
    logic       ch1_tick = 1'b0;
    logic       resync_req;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    phase_resync_ctrl i_phase_resync_ctrl (
        .clk        (clk),
        .rst        (rst),
        .resync_en  (resync_en),
        .cfg_byte   (cfg_byte),
        .stage2_tick(stage2_tick),
        .id_ok      (id_ok),
        .ch1_tick   (ch1_tick),
        .resync_req (resync_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: resync_req=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives for one clock, samples after the rising edge
    task automatic step(input logic t2, input logic ok, input logic t1, output logic r);
        stage2_tick = t2;
        id_ok       = ok;
        ch1_tick    = t1;
        @(negedge clk);
        stage2_tick = 1'b0;
        ch1_tick    = 1'b0;
        r = resync_req;
    endtask

    task automatic do_reset(input logic en, input logic [7:0] cfg);
        @(negedge clk);
        rst = 1'b1;
        resync_en = en;
        cfg_byte = cfg;
        stage2_tick = 1'b0;
        ch1_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset drops request", resync_req, 1'b0);
    endtask

    task automatic t_basic_threshold();
        logic r;
        do_reset(1'b1, 8'h03);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b0, r);
            chk("R3 score at threshold", r, 1'b0);
        end
        step(1'b1, 1'b0, 1'b0, r);
        chk("R1 R6 score above threshold", r, 1'b1);
        step(1'b0, 1'b0, 1'b0, r);
        chk("R10 single pulse", r, 1'b0);
    endtask

    task automatic t_leaky_and_clear();
        logic r;
        do_reset(1'b1, 8'h03);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, r);
        step(1'b1, 1'b1, 1'b0, r);
        chk("R2 down by two", r, 1'b0);
        step(1'b1, 1'b0, 1'b0, r);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R2 score three", r, 1'b0);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R2 score four", r, 1'b1);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R7 cleared after request", r, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, r);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b0, r);
            chk("R2 floor at zero", r, 1'b0);
        end
        step(1'b1, 1'b0, 1'b0, r);
        chk("R2 floor then four misses", r, 1'b1);
    endtask

    task automatic t_hysteresis();
        logic r;
        do_reset(1'b1, 8'h50);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R8 first request not held off", r, 1'b1);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R4 held off after request", r, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'b1, r);
            chk("R4 window not yet elapsed", r, 1'b0);
        end
        step(1'b0, 1'b0, 1'b1, r);
        chk("R4 window elapsed on fifth ch1 period", r, 1'b1);
    endtask

    task automatic t_same_cycle();
        logic r;
        do_reset(1'b1, 8'h21);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R3 equal not enough", r, 1'b0);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R3 above threshold", r, 1'b1);
        step(1'b0, 1'b0, 1'b1, r);
        step(1'b1, 1'b0, 1'b0, r);
        step(1'b1, 1'b0, 1'b0, r);
        chk("R4 hold one of two", r, 1'b0);
        step(1'b1, 1'b0, 1'b1, r);
        chk("R9 both strobes use updated values", r, 1'b1);
    endtask

    task automatic t_enable_gate();
        logic r;
        logic seen;
        do_reset(1'b0, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b0, r);
            seen = seen | r;
        end
        chk("R5 no request while disabled", seen, 1'b0);
        resync_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, r);
        chk("R5 counters tracked while disabled", r, 1'b1);
    endtask

    task automatic t_ceiling();
        logic r;
        do_reset(1'b0, 8'h0E);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, r);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, r);
        resync_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, r);
        chk("R1 ceiling at 31 then down to 15", r, 1'b1);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R10 request low in reset", resync_req, 1'b0);
        t_basic_threshold();
        t_leaky_and_clear();
        t_hysteresis();
        t_same_cycle();
        t_enable_gate();
        t_ceiling();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule